// File: doc/BRIEF.md
# Clocked Monostable Pulse Generator

This block turns a rising transition on an unsynchronised trigger line into a single high pulse whose length is a programmed number of clock cycles. Its only stable state is output low; a valid trigger edge moves it into a timed high state, and it drops back to low by itself once the count runs out. How long the trigger line is held high has no effect on the pulse width.

A run-time select picks one of two behaviours for edges that arrive while a pulse is running. In one-shot mode such edges are discarded, and the block only accepts a new edge once it is low again. In restart mode each such edge reloads the full interval, so closely spaced edges stretch the pulse. The trigger passes through a synchroniser and an edge detector inside the block. The pulse length and the mode are captured at the moment an edge is accepted.

Top module: `mono_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is low. A trigger line that is already high when reset is released produces no pulse.
- R2: After `trig_i` goes from low to high, `pulse_o` goes high on the third rising clock edge that samples the new level.
- R3: A pulse accepted with length value N (N > 0) keeps `pulse_o` high for exactly N clock cycles, whatever the trigger does afterwards.
- R4: A trigger line held high starts no further pulse, and the output returns low with no further input.
- R5: With `mode_i` = 0 (one-shot), a trigger edge detected while the output is high is ignored, including an edge detected in the last high cycle.
- R6: In one-shot mode, an edge detected in the first cycle after the output has returned low starts a new pulse.
- R7: With `mode_i` = 1 (restart), an edge detected while high reloads the full interval: the pulse ends N cycles after the load of that edge.
- R8: A length value of 0 captured with an edge produces no pulse.
- R9: `len_i` and `mode_i` are captured when an edge is accepted; changing them during a pulse alters neither its width nor how it treats further edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the environment |
| trig_i | input | 1 | Unsynchronised trigger line; rising transitions start pulses |
| mode_i | input | 1 | 0 = one-shot (edges while high ignored), 1 = restart on each edge |
| len_i | input | 16 | Pulse length in clock cycles; 0 suppresses the pulse |
| pulse_o | output | 1 | Timed output pulse |

## Verification
The hardest situations to reach from the ports are edges that land exactly on the final high cycle or on the first low cycle, since the boundary decides between ignoring, restarting and starting afresh. The stimulus reaches them by dropping and re-raising the trigger at chosen offsets from the first edge, counted through the three-cycle synchroniser latency, so the second edge is detected in precisely the last active cycle or in the first idle one. Mode and length are changed in the same cycle to show that the captured values, not the live ones, govern the running pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  typedef enum logic {
    MODE_ONCE    = 1'b0,
    MODE_RESTART = 1'b1
  } os_mode_e;

endpackage

// File: rtl/os_trig_sync.sv
// Synchroniser chain plus history flop; reports one-cycle rise strobes.
module os_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], async_i};
  end

  // Reset to all ones: a line that is high at release looks unchanged.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/os_pulse_timer.sv
// Down-counter with captured mode; decides acceptance of each strobe.
module os_pulse_timer
  import oneshot_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  os_mode_e         mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o
);

  localparam logic [LEN_W-1:0] LAST = LEN_W'(1);

  logic             active_q, active_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  os_mode_e         mode_q, mode_d;
  logic             accept;
  logic             upd_en;

  always_comb begin
    accept = fire_i && (len_i != '0) &&
             (!active_q || (mode_q == MODE_RESTART));
    upd_en   = accept || active_q;
    active_d = active_q;
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    if (accept) begin
      active_d = 1'b1;
      cnt_d    = len_i;
      mode_d   = mode_i;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q - LAST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      mode_q   <= MODE_ONCE;
    end else if (upd_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      mode_q   <= mode_d;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/mono_pulse_gen.sv
module mono_pulse_gen
  import oneshot_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             pulse_o
);

  logic     rise;
  os_mode_e mode_sel;

  assign mode_sel = os_mode_e'(mode_i);

  os_trig_sync #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (trig_i),
    .rise_o  (rise)
  );

  os_pulse_timer #(
    .LEN_W (LEN_W)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (rise),
    .mode_i   (mode_sel),
    .len_i    (len_i),
    .active_o (pulse_o)
  );

endmodule

// File: rtl/mono_pulse_gen_chk.sv
module mono_pulse_gen_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_i,
  input logic             mode_i,
  input logic [LEN_W-1:0] len_i,
  input logic             pulse_o
);

  logic             prev_pulse;
  logic [LEN_W-1:0] prev_len;
  logic             prev_mode;
  logic [LEN_W-1:0] len_cap;
  logic             mode_cap;
  logic [LEN_W:0]   run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pulse <= 1'b0;
      prev_len   <= '0;
      prev_mode  <= 1'b0;
      len_cap    <= '0;
      mode_cap   <= 1'b0;
      run        <= '0;
    end else begin
      prev_pulse <= pulse_o;
      prev_len   <= len_i;
      prev_mode  <= mode_i;
      if (pulse_o && !prev_pulse) begin
        len_cap  <= prev_len;
        mode_cap <= prev_mode;
        run      <= (LEN_W+1)'(1);
      end else if (pulse_o) begin
        run <= run + (LEN_W+1)'(1);
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_low_R1: assert (!pulse_o);
    end
  end

  assert_start_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(trig_i, 3) && !$past(trig_i, 4)));

  assert_nonzero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> ($past(len_i) != '0));

  assert_exact_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_pulse && !pulse_o && !mode_cap) |-> (run == {1'b0, len_cap}));

  assert_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_pulse && pulse_o && !mode_cap) |-> (run < {1'b0, len_cap}));

endmodule

bind mono_pulse_gen mono_pulse_gen_chk #(.LEN_W(LEN_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .trig_i  (trig_i),
  .mode_i  (mode_i),
  .len_i   (len_i),
  .pulse_o (pulse_o)
);

// File: tb/mono_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module mono_pulse_gen_tb_top;

  localparam int LEN_W = 16;
  localparam int STEPS = 80;

  logic             clk;
  logic             rst_n;
  logic             trig_i;
  logic             mode_i;
  logic [LEN_W-1:0] len_i;
  logic             pulse_o;

  int n_checks;
  int n_bad;
  bit finished;

  mono_pulse_gen #(.LEN_W(LEN_W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_i  (trig_i),
    .mode_i  (mode_i),
    .len_i   (len_i),
    .pulse_o (pulse_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input int act, input int exp, input string req, input string what);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic quiet();
    trig_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // Raises the trigger, then steps negedges applying scheduled changes
  // and samples the output. lead = first high step, width = high samples.
  task automatic measure(input int drop_at, input int rise2_at,
                         input int chg_at, input logic [LEN_W-1:0] chg_len,
                         input logic chg_mode,
                         output int lead, output int width, output int npulse);
    logic last;
    lead = -1; width = 0; npulse = 0; last = 1'b0;
    @(negedge clk);
    trig_i = 1'b1;
    for (int k = 1; k <= STEPS; k++) begin
      @(negedge clk);
      if (k == drop_at)  trig_i = 1'b0;
      if (k == rise2_at) trig_i = 1'b1;
      if (k == chg_at) begin
        len_i  = chg_len;
        mode_i = chg_mode;
      end
      if (pulse_o) begin
        if (lead < 0) lead = k;
        width++;
        if (!last) npulse++;
      end
      last = pulse_o;
    end
    quiet();
  endtask

  task automatic t_reset();
    trig_i = 1'b1; mode_i = 1'b0; len_i = 16'd5;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(int'(pulse_o), 0, "R1", "output during reset");
    rst_n = 1'b1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pulse_o) begin
        check(1, 0, "R1", "pulse after release with trigger high");
        break;
      end
    end
    check(int'(pulse_o), 0, "R1", "output after release");
    quiet();
  endtask

  task automatic t_basic();
    int lead, width, np;
    mode_i = 1'b0; len_i = 16'd5;
    measure(1000, 1000, 1000, 16'd0, 1'b0, lead, width, np);
    check(lead, 3, "R2", "start latency");
    check(width, 5, "R3", "width with trigger held");
    check(np, 1, "R4", "pulses while held high");
    check(int'(pulse_o), 0, "R4", "returned low");
    len_i = 16'd1;
    measure(2, 1000, 1000, 16'd0, 1'b0, lead, width, np);
    check(width, 1, "R3", "width of length 1");
  endtask

  task automatic t_once();
    int lead, width, np;
    mode_i = 1'b0; len_i = 16'd10;
    measure(2, 4, 1000, 16'd0, 1'b0, lead, width, np);
    check(width, 10, "R5", "width with mid-pulse edge");
    check(np, 1, "R5", "pulse count with mid-pulse edge");
    len_i = 16'd4;
    measure(2, 4, 1000, 16'd0, 1'b0, lead, width, np);
    check(width, 4, "R5", "edge in last high cycle width");
    check(np, 1, "R5", "edge in last high cycle count");
    measure(2, 5, 1000, 16'd0, 1'b0, lead, width, np);
    check(np, 2, "R6", "edge in first low cycle count");
    check(width, 8, "R6", "edge in first low cycle total");
  endtask

  task automatic t_restart();
    int lead, width, np;
    mode_i = 1'b1; len_i = 16'd6;
    measure(2, 4, 1000, 16'd0, 1'b1, lead, width, np);
    check(lead, 3, "R7", "restart start latency");
    check(width, 10, "R7", "stretched width");
    check(np, 1, "R7", "stretched pulse count");
    len_i = 16'd4;
    measure(2, 4, 1000, 16'd0, 1'b1, lead, width, np);
    check(width, 8, "R7", "reload on last high cycle");
  endtask

  task automatic t_zero();
    int lead, width, np;
    mode_i = 1'b0; len_i = 16'd0;
    measure(2, 1000, 1000, 16'd0, 1'b0, lead, width, np);
    check(width, 0, "R8", "zero length high samples");
    check(np, 0, "R8", "zero length pulse count");
  endtask

  task automatic t_capture();
    int lead, width, np;
    mode_i = 1'b0; len_i = 16'd4;
    measure(2, 4, 3, 16'd20, 1'b1, lead, width, np);
    check(width, 4, "R9", "width after mid-pulse change");
    check(np, 1, "R9", "edge ignored under captured mode");
    mode_i = 1'b1; len_i = 16'd3;
    measure(2, 1000, 3, 16'd30, 1'b0, lead, width, np);
    check(width, 3, "R9", "captured short length");
  endtask

  initial begin
    n_checks = 0; n_bad = 0; finished = 1'b0;
    trig_i = 1'b0; mode_i = 1'b0; len_i = '0; rst_n = 1'b0;
    t_reset();
    t_basic();
    t_once();
    t_restart();
    t_zero();
    t_capture();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule